// File: doc/BRIEF.md
# Framer Error-Counter Interrupt Bank

This block collects the event sources of an E1 framer into latched interrupt status bits. Each bit can be masked on its own, and each bit clears when its status byte is read. Six 8-bit error counters live inside the block: frame-alignment errors, CRC errors, E-bit errors, bipolar violations, PRBS errors and PRBS multiframes. Each counter counts its increment strobe, and its status bit is raised only when the counter rolls from all ones back to zero.

A second status byte gathers condition events:
- rising edges of the one-second and five-second timer levels;
- a remote alarm that coincides with a CRC error;
- the jitter-attenuator FIFO entering its near-overflow or near-underflow zone;
- a change of state in the signalling bits, either immediate or debounced.

A single active-high request output is the OR of every set status bit. Software reads a byte by giving a read strobe and an address. The read data shows the bits as they stood before the clear takes effect on the same clock edge.

Top module: `frm_irq_bank`

## Requirements
- R1: Each counter is CNT_W bits wide (8 by default) and wraps without saturating. Its status bit sets on the clock edge where a strobe takes the counter from all ones to zero, and not before. Byte 0 (rd_addr 0) holds these bits: bit 0 frame-alignment, bit 1 CRC, bit 2 E-bit, bit 3 bipolar violation, bit 4 PRBS error, bit 5 PRBS multiframe.
- R2: A source whose mask bit is 0 never sets its status bit, and a mask bit of 1 lets it set. mask_cnt bits follow the byte 0 order and mask_cond bits follow the byte 1 order.
- R3: When rd_en is high, rd_data shows the addressed byte, and on that clock edge the bits of that byte are cleared. The other byte is not affected.
- R4: A source event that arrives in the same cycle as a read of its byte leaves its bit set after the clear.
- R5: Byte 1 (rd_addr 1) bit 0 sets on a rising edge of lvl_1s, and bit 1 sets on a rising edge of lvl_5s. A level that stays high does not set the bit again after it has been cleared.
- R6: Byte 1 bit 2 sets only when remote_alarm and ev_crc are high in the same cycle.
- R7: Byte 1 bit 3 sets when ja_fill enters the zone where ja_fill <= JA_MARGIN or ja_fill >= JA_DEPTH-JA_MARGIN. It does not set again while ja_fill stays inside that zone.
- R8: With debounce off, byte 1 bit 4 sets on the edge where the compared signalling bits differ from the last accepted value. With sig_four=0 only bits [3:2] are compared; with sig_four=1 all four bits are compared.
- R9: With sig_db_en=1, a signalling change is accepted only after the new value has been sampled on DB_CYC consecutive edges. A shorter excursion that returns to the accepted value is ignored.
- R10: irq is high exactly when at least one status bit is set.
- R11: A synchronous reset clears all counters and all status bits.
- R12: Unused status bits, unassigned addresses and rd_data while rd_en is low all read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_fas | input | 1 | Frame-alignment error increment |
| ev_crc | input | 1 | CRC error increment |
| ev_ebit | input | 1 | E-bit error increment |
| ev_bpv | input | 1 | Bipolar violation increment |
| ev_prbs | input | 1 | PRBS error increment |
| ev_prbs_mf | input | 1 | PRBS multiframe increment |
| lvl_1s | input | 1 | One-second status level |
| lvl_5s | input | 1 | Five-second status level |
| remote_alarm | input | 1 | Remote alarm flag |
| ja_fill | input | FILL_W | Jitter-attenuator FIFO fill in bytes |
| sig_bits | input | 4 | Signalling bits ABCD, A in bit 3 |
| sig_four | input | 1 | 1 compares ABCD, 0 compares AB only |
| sig_db_en | input | 1 | Debounce enable for signalling changes |
| mask_cnt | input | 6 | Counter source masks, 1 = enabled |
| mask_cond | input | 5 | Condition source masks, 1 = enabled |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Status byte select |
| rd_data | output | 8 | Read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench keeps CNT_W at 8 and DB_CYC at 3. A full counter wrap therefore needs only 256 strobes per source, and every counter can be wrapped, masked and raced against a read within the cycle budget. JA_DEPTH is set to 16 with JA_MARGIN 4. This places both zone boundaries (4 and 12) and their neighbours (5 and 13) within a few steps of a mid fill. With a three-sample debounce, a two-sample glitch and a three-sample hold can be told apart edge by edge through irq, without a read that would clear the bit.

// File: rtl/frm_irq_bank.sv
module frm_irq_bank #(
  parameter int CNT_W      = 8,
  parameter int JA_DEPTH   = 32,
  parameter int JA_MARGIN  = 4,
  parameter int DB_CYC     = 3,
  parameter int FILL_W     = $clog2(JA_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_fas,
  input  logic              ev_crc,
  input  logic              ev_ebit,
  input  logic              ev_bpv,
  input  logic              ev_prbs,
  input  logic              ev_prbs_mf,
  input  logic              lvl_1s,
  input  logic              lvl_5s,
  input  logic              remote_alarm,
  input  logic [FILL_W-1:0] ja_fill,
  input  logic [3:0]        sig_bits,
  input  logic              sig_four,
  input  logic              sig_db_en,
  input  logic [5:0]        mask_cnt,
  input  logic [4:0]        mask_cond,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq
);

  localparam int NCNT  = 6;
  localparam int NCOND = 5;
  localparam int RUN_W = $clog2(DB_CYC + 1);
  localparam logic [FILL_W-1:0] FILL_LO  = FILL_W'(JA_MARGIN);
  localparam logic [FILL_W-1:0] FILL_HI  = FILL_W'(JA_DEPTH - JA_MARGIN);
  localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(DB_CYC);

  logic [NCNT-1:0]  inc, wrap, set_cnt, st_cnt;
  logic [NCOND-1:0] cond, set_cond, st_cond;
  logic [CNT_W-1:0] cnt [NCNT];

  assign inc = {ev_prbs_mf, ev_prbs, ev_bpv, ev_ebit, ev_crc, ev_fas};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    assign wrap[i] = inc[i] & (&cnt[i]);
    always_ff @(posedge clk) begin
      if (rst)         cnt[i] <= '0;
      else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
    end
  end

  // timer edges, coincident alarm, FIFO zone entry
  logic q_1s, q_5s, q_near;
  logic ja_near;
  assign ja_near = (ja_fill <= FILL_LO) || (ja_fill >= FILL_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_1s   <= 1'b0;
      q_5s   <= 1'b0;
      q_near <= 1'b0;
    end else begin
      q_1s   <= lvl_1s;
      q_5s   <= lvl_5s;
      q_near <= ja_near;
    end
  end

  // signalling change detector with optional debounce
  logic [3:0]       acc, cand, cmp;
  logic [RUN_W-1:0] run, run_nx;
  logic             diff, new_cand, sig_acc;

  assign cmp      = sig_four ? 4'hF : 4'hC;
  assign diff     = (sig_bits & cmp) != (acc & cmp);
  assign new_cand = (sig_bits & cmp) != (cand & cmp);
  assign run_nx   = (new_cand ? '0 : run) + 1'b1;
  assign sig_acc  = diff && (!sig_db_en || run_nx >= RUN_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      cand <= '0;
      run  <= '0;
    end else if (sig_acc) begin
      acc  <= sig_bits;
      cand <= sig_bits;
      run  <= '0;
    end else if (diff) begin
      cand <= sig_bits;
      run  <= run_nx;
    end else begin
      run  <= '0;
    end
  end

  assign cond = {sig_acc,
                 ja_near & ~q_near,
                 remote_alarm & ev_crc,
                 lvl_5s & ~q_5s,
                 lvl_1s & ~q_1s};

  assign set_cnt  = wrap & mask_cnt;
  assign set_cond = cond & mask_cond;

  logic rd_cnt, rd_cond;
  assign rd_cnt  = rd_en && rd_addr == 2'd0;
  assign rd_cond = rd_en && rd_addr == 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_cnt  <= '0;
      st_cond <= '0;
    end else begin
      st_cnt  <= (rd_cnt  ? '0 : st_cnt)  | set_cnt;
      st_cond <= (rd_cond ? '0 : st_cond) | set_cond;
    end
  end

  assign rd_data = rd_cnt  ? {2'b00, st_cnt}   :
                   rd_cond ? {3'b000, st_cond} : 8'h00;
  assign irq = |{st_cnt, st_cond};

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (ev_fas && cnt[0] == '1 && mask_cnt[0]) |=> st_cnt[0]);

  assert_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (!st_cnt[1] && !mask_cnt[1] && !rd_cnt) |=> !st_cnt[1]);

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_cond && set_cond == '0) |=> st_cond == '0);

  assert_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_cnt && set_cnt[1]) |=> st_cnt[1]);

  assert_sec_R5: assert property (@(posedge clk) disable iff (rst)
    (lvl_1s && !q_1s && mask_cond[0]) |=> st_cond[0]);

  assert_zone_R7: assert property (@(posedge clk) disable iff (rst)
    (ja_near && !q_near && mask_cond[3]) |=> st_cond[3]);

  assert_irq_R10: assert property (@(posedge clk) disable iff (rst)
    (st_cnt == '0 && st_cond == '0) |-> !irq);

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> (st_cnt == '0 && st_cond == '0 && cnt[0] == '0));

  assert_unused_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rd_data == 8'h00);

endmodule

// File: tb/tb_frm_irq_bank.sv
module tb_frm_irq_bank;
  localparam int FW = $clog2(16 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] ev = '0;
  logic lvl_1s = 0, lvl_5s = 0, remote_alarm = 0;
  logic [FW-1:0] ja_fill = FW'(8);
  logic [3:0] sig_bits = '0;
  logic sig_four = 0, sig_db_en = 0;
  logic [5:0] mask_cnt = '1;
  logic [4:0] mask_cond = '1;
  logic rd_en = 0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frm_irq_bank #(.CNT_W(8), .JA_DEPTH(16), .JA_MARGIN(4), .DB_CYC(3)) dut (
    .clk(clk), .rst(rst),
    .ev_fas(ev[0]), .ev_crc(ev[1]), .ev_ebit(ev[2]), .ev_bpv(ev[3]),
    .ev_prbs(ev[4]), .ev_prbs_mf(ev[5]),
    .lvl_1s(lvl_1s), .lvl_5s(lvl_5s), .remote_alarm(remote_alarm),
    .ja_fill(ja_fill), .sig_bits(sig_bits), .sig_four(sig_four),
    .sig_db_en(sig_db_en), .mask_cnt(mask_cnt), .mask_cond(mask_cond),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic strobes(input int idx, input int n);
    @(negedge clk); ev[idx] = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); ev[idx] = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk("R11 byte0 after reset", d, 8'h00);
    rd(1, d); chk("R11 byte1 after reset", d, 8'h00);
    chk("R10 irq idle", {7'b0, irq}, 8'h00);
    rd(2, d); chk("R12 unassigned address", d, 8'h00);
    #1 chk("R12 idle rd_data", rd_data, 8'h00);
    strobes(0, 200);
    @(negedge clk); lvl_1s = 1;
    @(negedge clk); lvl_1s = 0;
    chk("R10 irq with bit set", {7'b0, irq}, 8'h01);
    rst = 1; @(negedge clk); rst = 0;
    rd(1, d); chk("R11 status cleared by reset", d, 8'h00);
    strobes(0, 255);
    rd(0, d); chk("R11 counter cleared, 255 strobes no wrap", d, 8'h00);
  endtask

  task automatic t_wraps;
    logic [7:0] d;
    strobes(0, 1);
    chk("R10 irq after wrap", {7'b0, irq}, 8'h01);
    rd(0, d); chk("R1 frame-alignment wrap", d, 8'h01);
    rd(0, d); chk("R3 cleared after read", d, 8'h00);
    for (int i = 1; i < 6; i++) begin
      strobes(i, 255);
      rd(0, d); chk("R1 no set before wrap", d, 8'h00);
      strobes(i, 1);
      rd(0, d); chk("R1 wrap bit position", d, 8'(1 << i));
    end
  endtask

  task automatic t_mask;
    logic [7:0] d;
    mask_cnt = 6'b111101;
    strobes(1, 256);
    rd(0, d); chk("R2 masked CRC wrap", d, 8'h00);
    mask_cnt = '1;
    mask_cond = 5'b11110;
    @(negedge clk); lvl_1s = 1;
    @(negedge clk); lvl_1s = 0;
    rd(1, d); chk("R2 masked one-second edge", d, 8'h00);
    mask_cond = '1;
  endtask

  task automatic t_race;
    logic [7:0] d;
    strobes(1, 255);
    @(negedge clk); lvl_5s = 1;
    @(negedge clk); ev[1] = 1; rd_en = 1; rd_addr = 0;
    #1 d = rd_data;
    @(negedge clk); ev[1] = 0; rd_en = 0; lvl_5s = 0;
    chk("R4 read data before race", d, 8'h00);
    rd(0, d); chk("R4 event wins over read", d, 8'h02);
    rd(1, d); chk("R3 other byte untouched", d, 8'h02);
  endtask

  task automatic t_seconds;
    logic [7:0] d;
    @(negedge clk); lvl_1s = 1;
    @(negedge clk);
    rd(1, d); chk("R5 one-second rise", d, 8'h01);
    repeat (3) @(negedge clk);
    rd(1, d); chk("R5 held level no re-set", d, 8'h00);
    lvl_1s = 0;
    @(negedge clk); lvl_5s = 1;
    @(negedge clk);
    rd(1, d); chk("R5 five-second rise", d, 8'h02);
    lvl_5s = 0;
  endtask

  task automatic t_rcr;
    logic [7:0] d;
    @(negedge clk); remote_alarm = 1;
    @(negedge clk); remote_alarm = 0;
    strobes(1, 1);
    rd(1, d); chk("R6 separate alarm and CRC", d, 8'h00);
    @(negedge clk); remote_alarm = 1; ev[1] = 1;
    @(negedge clk); remote_alarm = 0; ev[1] = 0;
    rd(1, d); chk("R6 coincident alarm and CRC", d, 8'h04);
  endtask

  task automatic t_ja;
    logic [7:0] d;
    @(negedge clk); ja_fill = FW'(5);
    @(negedge clk);
    rd(1, d); chk("R7 fill 5 outside zone", d, 8'h00);
    @(negedge clk); ja_fill = FW'(12);
    @(negedge clk);
    rd(1, d); chk("R7 near overflow at 12", d, 8'h08);
    @(negedge clk); ja_fill = FW'(13);
    @(negedge clk);
    rd(1, d); chk("R7 stays in zone no re-set", d, 8'h00);
    @(negedge clk); ja_fill = FW'(8);
    @(negedge clk); ja_fill = FW'(4);
    @(negedge clk);
    rd(1, d); chk("R7 near underflow at 4", d, 8'h08);
    ja_fill = FW'(8);
    @(negedge clk);
  endtask

  task automatic t_sig;
    logic [7:0] d;
    @(negedge clk); sig_four = 0; sig_bits = 4'b0011;
    repeat (2) @(negedge clk);
    rd(1, d); chk("R8 CD bits ignored in AB mode", d, 8'h00);
    @(negedge clk); sig_bits = 4'b1011;
    @(negedge clk);
    rd(1, d); chk("R8 AB change detected", d, 8'h10);
    @(negedge clk); sig_four = 1; sig_bits = 4'b1010;
    @(negedge clk);
    rd(1, d); chk("R8 D bit change in ABCD mode", d, 8'h10);
  endtask

  task automatic t_debounce;
    logic [7:0] d;
    @(negedge clk); sig_db_en = 1; sig_bits = 4'b1110;
    repeat (2) @(negedge clk);
    sig_bits = 4'b1010;
    repeat (3) @(negedge clk);
    rd(1, d); chk("R9 short glitch ignored", d, 8'h00);
    @(negedge clk); sig_bits = 4'b1110;
    repeat (2) @(negedge clk);
    chk("R9 not yet after two samples", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R9 accepted after three samples", {7'b0, irq}, 8'h01);
    rd(1, d); chk("R9 debounced change bit", d, 8'h10);
    sig_db_en = 0;
    chk("R10 irq low after all cleared", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_wraps();
    t_mask();
    t_race();
    t_seconds();
    t_rcr();
    t_ja();
    t_sig();
    t_debounce();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule